// File: doc/BRIEF.md
# Synchronous Burst Byte FIFO Port

This block is the device side of an 8-bit parallel port that a host runs synchronously to a clock the device supplies. Inside the port are two FIFOs. The receive FIFO is loaded by the core and emptied by the host. The transmit FIFO is loaded by the host and emptied by the core. The host sees two active-low flags: "data available" (`rxf_n_o`) and "space available" (`txe_n_o`). It drives three active-low controls: read strobe, write strobe and output enable. All of them are sampled on the rising edge of the supplied clock.

To read, the host first drops output enable, which turns on the port's drive of the data bus. It then holds the read strobe low, and one byte leaves the receive FIFO on every clock for as long as the data-available flag stays low. To write, the host keeps output enable high and holds the write strobe low, and one byte enters the transmit FIFO on every clock for as long as the space-available flag stays low. The clock output is a free-running copy of the core clock, so the core side and the host side share one clock domain.

Both flags are registered and follow FIFO occupancy from cycle to cycle. A flag rises on the same edge that takes the last byte out of the receive FIFO, or puts the last free entry of the transmit FIFO to use. A strobe that arrives when no transfer is possible has no effect.

Top module: `sync_fifo_port`

## Requirements
- R1: After reset, `rxf_n_o` is 1, `txe_n_o` is 0, `tx_empty_o` is 1 and `rx_full_o` is 0.
- R2: `host_data_oe_o` is 1 exactly while `oe_n_i` is 0. While it is 0, `host_data_o` reads 0. While it is 1 and the receive FIFO holds data, `host_data_o` shows the oldest receive byte.
- R3: On a rising edge at which `rxf_n_o`, `oe_n_i` and `rd_n_i` are all 0, the oldest receive byte is removed, and the next byte appears on `host_data_o` after that edge.
- R4: If `rd_n_i` is 0 while `oe_n_i` is 1, no byte is removed.
- R5: While `oe_n_i` and `rd_n_i` are held low, one byte is read per clock with no gap, in the order the core pushed the bytes.
- R6: `rxf_n_o` goes to 0 after the edge at which the core pushes a byte into an empty receive FIFO. It goes to 1 after the edge at which the last byte is read.
- R7: On a rising edge at which `txe_n_o` and `wr_n_i` are 0 and `oe_n_i` is 1, `host_data_i` is stored. Held strobes store one byte per clock, and the core reads the bytes back on `tx_data_o` in the order they were written.
- R8: A host write strobe given while `oe_n_i` is 0 stores nothing.
- R9: `txe_n_o` goes to 1 after the edge that fills the transmit FIFO. Host writes while it is 1 are ignored, and the stored bytes stay unchanged.
- R10: A host read strobe while `rxf_n_o` is 1 removes nothing. The next byte the core pushes is the next byte the host reads.
- R11: The core side follows the same rules. `rx_wr_i` while `rx_full_o` is 1 is ignored. `tx_rd_i` while `tx_empty_o` is 1 is ignored. `tx_data_o` shows the oldest transmit byte while `tx_empty_o` is 0, and `tx_rd_i` removes it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_clk_o | output | 1 | Clock supplied to the host |
| rxf_n_o | output | 1 | Receive data available, active low |
| txe_n_o | output | 1 | Transmit space available, active low |
| rd_n_i | input | 1 | Host read strobe, active low |
| wr_n_i | input | 1 | Host write strobe, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| host_data_i | input | 8 | Byte written by the host |
| host_data_o | output | 8 | Byte presented to the host |
| host_data_oe_o | output | 1 | Data bus drive enable |
| rx_wr_i | input | 1 | Core push into the receive FIFO |
| rx_data_i | input | 8 | Byte pushed by the core |
| rx_full_o | output | 1 | Receive FIFO full |
| tx_rd_i | input | 1 | Core pop from the transmit FIFO |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_empty_o | output | 1 | Transmit FIFO empty |

## Verification
The flags and the next read byte change on the edge that performs a transfer, because the flags are registered and the data is taken from the FIFO head. The bus enable and the gated data follow `oe_n_i` with no cycle of delay. The bench drives inputs 2 ns after each rising edge and samples on the falling edge. For every edge, its monitor therefore sees the data and flags that the edge is about to use, and it compares data on the exact cycles in which a transfer is qualified. Flag checks are taken on the falling edge that follows the edge that should have changed them.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic logic host_rd_ok(logic rxf_n, logic oe_n, logic rd_n);
    return !rxf_n && !oe_n && !rd_n;
  endfunction

  function automatic logic host_wr_ok(logic txe_n, logic oe_n, logic wr_n);
    return !txe_n && oe_n && !wr_n;
  endfunction
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    cnt_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             empty_q, full_q;
  logic             push_ok, pop_ok;

  assign push_ok = push_i && !full_q;
  assign pop_ok  = pop_i && !empty_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      empty_q  <= 1'b1;
      full_q   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q   <= cnt_d;
      empty_q <= (cnt_d == '0);
      full_q  <= (cnt_d == CW'(DEPTH));
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (push_ok && (wr_ptr_q == AW'(i))) mem_q[i] <= din_i;
    end
  end

  assign dout_o  = mem_q[rd_ptr_q];
  assign empty_o = empty_q;
  assign full_o  = full_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sync_fifo_port.sv
module sync_fifo_port
  import sfp_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned TX_DEPTH = 8,
  localparam int unsigned RX_CW = ((RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1) + 1,
  localparam int unsigned TX_CW = ((TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              host_clk_o,
  output logic              rxf_n_o,
  output logic              txe_n_o,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              oe_n_i,
  input  logic [BYTE_W-1:0] host_data_i,
  output logic [BYTE_W-1:0] host_data_o,
  output logic              host_data_oe_o,
  input  logic              rx_wr_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_full_o,
  input  logic              tx_rd_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_empty_o
);
  byte_t            rx_head;
  logic             rx_empty, tx_full;
  logic             host_rd, host_wr;
  logic [RX_CW-1:0] rx_cnt;
  logic [TX_CW-1:0] tx_cnt;

  assign host_clk_o = clk_i;
  assign rxf_n_o    = rx_empty;
  assign txe_n_o    = tx_full;
  assign host_rd    = host_rd_ok(rx_empty, oe_n_i, rd_n_i);
  assign host_wr    = host_wr_ok(tx_full, oe_n_i, wr_n_i);

  sfp_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_wr_i), .din_i(rx_data_i),
    .pop_i(host_rd),  .dout_o(rx_head),
    .empty_o(rx_empty), .full_o(rx_full_o), .cnt_o(rx_cnt)
  );

  sfp_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(host_wr), .din_i(host_data_i),
    .pop_i(tx_rd_i),  .dout_o(tx_data_o),
    .empty_o(tx_empty_o), .full_o(tx_full), .cnt_o(tx_cnt)
  );

  assign host_data_oe_o = !oe_n_i;
  assign host_data_o    = host_data_oe_o ? rx_head : '0;
endmodule

// File: rtl/sync_fifo_port_chk.sv
module sync_fifo_port_chk #(
  parameter int unsigned RX_CW = 4,
  parameter int unsigned TX_CW = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rxf_n_o,
  input logic             txe_n_o,
  input logic             rd_n_i,
  input logic             wr_n_i,
  input logic             oe_n_i,
  input logic             rx_wr_i,
  input logic             tx_rd_i,
  input logic [RX_CW-1:0] rx_cnt,
  input logic [TX_CW-1:0] tx_cnt
);
  AST_RXF_TRACKS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_n_o == (rx_cnt == '0)); // R6

  AST_RD_POPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rxf_n_o && !oe_n_i && !rd_n_i && !rx_wr_i) |=> rx_cnt == RX_CW'($past(rx_cnt) - 1'b1)); // R3

  AST_RD_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_n_i && !rx_wr_i) |=> $stable(rx_cnt)); // R4

  AST_NO_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxf_n_o && !rx_wr_i) |=> rxf_n_o); // R10

  AST_WR_PUSHES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txe_n_o && !wr_n_i && oe_n_i && !tx_rd_i) |=> tx_cnt == TX_CW'($past(tx_cnt) + 1'b1)); // R7

  AST_WR_BLOCKED_BY_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_n_i && !tx_rd_i) |=> $stable(tx_cnt)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txe_n_o && !tx_rd_i) |=> (txe_n_o && $stable(tx_cnt))); // R9
endmodule

bind sync_fifo_port sync_fifo_port_chk #(.RX_CW(RX_CW), .TX_CW(TX_CW)) u_chk (
  .clk_i, .rst_ni, .rxf_n_o, .txe_n_o, .rd_n_i, .wr_n_i, .oe_n_i,
  .rx_wr_i, .tx_rd_i, .rx_cnt, .tx_cnt
);

// File: tb/sync_fifo_port_test.sv
module sync_fifo_port_test;
  localparam int unsigned DEPTH = 8;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       host_clk, rxf_n, txe_n, rd_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
  logic [7:0] hdi = '0, hdo, rx_data = '0, tx_data;
  logic       hoe, rx_wr = 1'b0, rx_full, tx_rd = 1'b0, tx_empty;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] rxq[$], txq[$];

  always #5 clk = ~clk;

  sync_fifo_port #(.RX_DEPTH(DEPTH), .TX_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni, .host_clk_o(host_clk), .rxf_n_o(rxf_n), .txe_n_o(txe_n),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .oe_n_i(oe_n), .host_data_i(hdi),
    .host_data_o(hdo), .host_data_oe_o(hoe), .rx_wr_i(rx_wr), .rx_data_i(rx_data),
    .rx_full_o(rx_full), .tx_rd_i(tx_rd), .tx_data_o(tx_data), .tx_empty_o(tx_empty)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // core pushes bytes toward the host
  task automatic core_push(logic [7:0] b);
    rx_wr = 1'b1; rx_data = b;
    if (!rx_full) rxq.push_back(b);
    step();
    rx_wr = 1'b0;
  endtask

  // host writes bytes with output enable high
  task automatic host_write(logic [7:0] b);
    oe_n = 1'b1; wr_n = 1'b0; hdi = b;
    if (!txe_n) txq.push_back(b);
    step();
    wr_n = 1'b1;
  endtask

  task automatic host_read_burst(int n);
    oe_n = 1'b0; rd_n = 1'b0;
    repeat (n) step();
    rd_n = 1'b1;
  endtask

  task automatic core_drain(int n);
    tx_rd = 1'b1;
    repeat (n) step();
    tx_rd = 1'b0;
  endtask

  // monitor: compare data on every qualified transfer edge
  always @(negedge clk) if (rst_ni) begin
    if (!rxf_n && !oe_n && !rd_n) begin
      if (rxq.size() == 0) chk("R5 unexpected host read", 1, 0);
      else chk("R3/R5 host read byte", hdo, rxq.pop_front());
    end
    if (tx_rd && !tx_empty) begin
      if (txq.size() == 0) chk("R7 unexpected core byte", 1, 0);
      else chk("R7/R11 core tx byte", tx_data, txq.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    settle();
    chk("R1 rxf_n", rxf_n, 1); chk("R1 txe_n", txe_n, 0);
    chk("R1 tx_empty", tx_empty, 1); chk("R1 rx_full", rx_full, 0);
    step();

    core_push(8'h11);
    settle(); chk("R6 rxf_n low after push", rxf_n, 0);
    chk("R2 no drive oe high", hoe, 0); chk("R2 data zero when idle", hdo, 0);
    step();
    core_push(8'h22); core_push(8'h33);

    oe_n = 1'b0; #1;
    chk("R2 drive with oe low", hoe, 1); chk("R2 head on bus", hdo, 8'h11);
    oe_n = 1'b1; rd_n = 1'b0;
    repeat (2) step();
    rd_n = 1'b1; oe_n = 1'b0; #1;
    chk("R4 head kept when oe high", hdo, 8'h11);
    step();

    host_read_burst(4);  // 3 bytes, then strobe while empty
    settle(); chk("R6 rxf_n high after last read", rxf_n, 1);
    chk("R10 empty stays empty", rxf_n, 1);
    step();
    core_push(8'h5A);
    host_read_burst(1);
    settle(); chk("R10 queue drained after refill", rxq.size(), 0);
    step();
    oe_n = 1'b1;

    host_write(8'hA1); host_write(8'hA2); host_write(8'hA3); host_write(8'hA4);
    oe_n = 1'b0; wr_n = 1'b0; hdi = 8'hEE;
    repeat (2) step();
    wr_n = 1'b1; oe_n = 1'b1;
    core_drain(5);
    settle(); chk("R8 no extra byte stored", tx_empty, 1);
    chk("R7 all written bytes seen", txq.size(), 0);
    step();

    for (int i = 0; i < DEPTH + 2; i++) host_write(8'hC0 + 8'(i));
    settle(); chk("R9 txe_n high when full", txe_n, 1);
    chk("R9 overflow bytes dropped", txq.size(), DEPTH);
    step();
    core_drain(DEPTH + 1);
    settle(); chk("R9 contents intact", txq.size(), 0);
    chk("R11 pop while empty", tx_empty, 1);
    step();

    for (int i = 0; i < DEPTH + 2; i++) core_push(8'h70 + 8'(i));
    settle(); chk("R11 rx_full set", rx_full, 1);
    chk("R11 extra core pushes dropped", rxq.size(), DEPTH);
    step();
    host_read_burst(DEPTH);
    settle(); chk("R5 burst complete", rxq.size(), 0);
    chk("R6 rxf_n high after burst", rxf_n, 1);
    step();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule